// File: doc/BRIEF.md
# Illegal Opcode Trap Unit

This unit sits at the execute stage and inspects every 32-bit instruction word handed to it with a valid strobe. When the word matches a reserved illegal-opcode encoding, it enters the exception trap in a single clock edge. On that edge it saves the offending instruction's PC into a debug PC register and the pre-trap status word into a debug status register. It also sets the non-maskable, exception-pending and interrupt-disable bits of the status word and redirects the program counter to a fixed handler vector. A one-cycle redirect pulse tells the fetch logic to discard its stream.

For any other valid instruction, the unit advances the PC by the instruction length given with it and leaves all other state alone. A small write port lets software load the debug PC, the debug status word and the status word itself. A trap takes precedence over a write in the same cycle.

Top module: `illop_trap`

## Requirements
- R1: During and right after reset, `pc` equals `RESET_PC`, `psw` equals 0x00000020, `dbg_pc` and `dbg_psw` are 0, and `redirect` is 0.
- R2: A word is illegal exactly when bits 10:5 are 111111b, bits 26:23 lie in 0111b..1111b and bit 16 is 0. An illegal word accepted with `ex_valid` high traps on that clock edge.
- R3: On a trap, `dbg_pc` takes the `ex_pc` of the offending instruction.
- R4: On a trap, `dbg_psw` takes the value `psw` held just before the trap edge.
- R5: On a trap, `psw` bits 7 (NP), 6 (EP) and 5 (ID) become 1, and bits 4:0 (SAT, CY, OV, S, Z at 4,3,2,1,0) keep their values.
- R6: On a trap, `pc` becomes `VECTOR` (0x00000060 by default), and `redirect` is high for exactly the cycle that follows each trapping edge.
- R7: A valid legal instruction loads `pc` with `ex_pc + ex_len` and leaves `dbg_pc`, `dbg_psw` and `psw` unchanged. `redirect` stays low.
- R8: With `ex_valid` low, `pc`, `psw`, `dbg_pc` and `dbg_psw` hold, whatever the instruction word is.
- R9: A word with bits 10:5 = 111111b does not trap when bits 26:23 are 0000b..0110b or when bit 16 is 1. A word does not trap when bits 10:5 are anything but 111111b.
- R10: With `wr_en` high, `wr_sel` 0 writes `dbg_pc`, 1 writes `dbg_psw`, and 2 writes `psw`. Code 3 writes nothing. A trap in the same cycle overrides the write.
- R11: Bits 31:8 of `psw` always read as zero, including after a write of nonzero upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ex_valid | input | 1 | Instruction in execute is valid |
| ex_insn | input | 32 | Instruction word |
| ex_pc | input | 32 | PC of the instruction |
| ex_len | input | LEN_W | Instruction length in bytes |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 debug PC, 1 debug PSW, 2 PSW |
| wr_data | input | 32 | Write data |
| pc | output | 32 | Next PC |
| psw | output | 32 | Status word |
| dbg_pc | output | 32 | Saved restart PC |
| dbg_psw | output | 32 | Saved status word |
| redirect | output | 1 | One-cycle pulse after a trap |

## Verification
The properties assume `ex_insn`, `ex_pc` and `ex_len` are known whenever `ex_valid` is high. They also assume that `wr_sel` is meaningful only while `wr_en` is high. The stability properties relate register values only when neither a write nor a trap happened on the previous edge. The stimulus therefore drives every input to a defined value on every cycle, including idle ones. It mixes writes, traps, legal instructions and idle cycles, including a write and a trap on the same edge. Sub-opcode values straddle the 0110b/0111b boundary, and bit 16 and the main opcode field are varied one at a time.

// File: rtl/illop_trap.sv
module illop_trap #(
  parameter int          LEN_W    = 3,
  parameter logic [31:0] VECTOR   = 32'h0000_0060,
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ex_valid,
  input  logic [31:0]      ex_insn,
  input  logic [31:0]      ex_pc,
  input  logic [LEN_W-1:0] ex_len,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [31:0]      wr_data,
  output logic [31:0]      pc,
  output logic [31:0]      psw,
  output logic [31:0]      dbg_pc,
  output logic [31:0]      dbg_psw,
  output logic             redirect
);
  localparam logic [7:0] PSW_RST  = 8'h20;
  localparam logic [7:0] TRAP_SET = 8'hE0;

  logic [7:0] st;
  logic       bad, trap;

  assign bad  = (ex_insn[10:5] == 6'h3F) && (ex_insn[26:23] >= 4'd7) && !ex_insn[16];
  assign trap = ex_valid && bad;
  assign psw  = {24'h0, st};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc       <= RESET_PC;
      st       <= PSW_RST;
      dbg_pc   <= '0;
      dbg_psw  <= '0;
      redirect <= 1'b0;
    end else begin
      redirect <= trap;
      if (trap) begin
        dbg_pc  <= ex_pc;
        dbg_psw <= psw;
        st      <= st | TRAP_SET;
        pc      <= VECTOR;
      end else begin
        if (ex_valid) pc <= ex_pc + {{(32-LEN_W){1'b0}}, ex_len};
        if (wr_en) begin
          case (wr_sel)
            2'd0:    dbg_pc  <= wr_data;
            2'd1:    dbg_psw <= wr_data;
            2'd2:    st      <= wr_data[7:0];
            default: ;
          endcase
        end
      end
    end
  end
endmodule

module illop_trap_chk #(
  parameter int          LEN_W  = 3,
  parameter logic [31:0] VECTOR = 32'h0000_0060
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ex_valid,
  input logic [31:0]      ex_insn,
  input logic [31:0]      ex_pc,
  input logic [LEN_W-1:0] ex_len,
  input logic             wr_en,
  input logic [31:0]      pc,
  input logic [31:0]      psw,
  input logic [31:0]      dbg_pc,
  input logic [31:0]      dbg_psw,
  input logic             redirect
);
  // R3
  trap_dbgpc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> dbg_pc == $past(ex_pc));
  // R4
  trap_dbgpsw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> dbg_psw == $past(psw));
  // R5
  trap_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> psw[7:5] == 3'b111 && psw[4:0] == $past(psw[4:0]));
  // R6
  trap_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> pc == VECTOR);
  // R6
  redirect_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> $past(ex_valid));
  // R7
  legal_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ex_valid) && !redirect |-> pc == $past(ex_pc) + 32'($past(ex_len)));
  // R7
  legal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect && !$past(wr_en) |-> $stable(psw) && $stable(dbg_pc) && $stable(dbg_psw));
  // R8
  idle_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ex_valid) |-> $stable(pc) && !redirect);
  // R9
  subop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ex_valid) && $past(ex_insn[26:23]) < 4'd7 |-> !redirect);
  // R9
  bit16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ex_valid) && $past(ex_insn[16]) |-> !redirect);
  // R11
  psw_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    psw[31:8] == 24'h0);
endmodule

bind illop_trap illop_trap_chk #(.LEN_W(LEN_W), .VECTOR(VECTOR)) i_chk (
  .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_insn(ex_insn), .ex_pc(ex_pc),
  .ex_len(ex_len), .wr_en(wr_en), .pc(pc), .psw(psw), .dbg_pc(dbg_pc),
  .dbg_psw(dbg_psw), .redirect(redirect)
);

// File: tb/test_illop_trap.sv
module test_illop_trap;
  logic        clk = 0, rst_n = 0;
  logic        ex_valid = 0, wr_en = 0;
  logic [31:0] ex_insn = 0, ex_pc = 0, wr_data = 0;
  logic [2:0]  ex_len = 0;
  logic [1:0]  wr_sel = 0;
  logic [31:0] pc, psw, dbg_pc, dbg_psw;
  logic        redirect;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;
  longint m_pc, m_psw, m_dpc, m_dpsw;
  bit m_red;

  always #2 clk = ~clk;

  illop_trap i_illop_trap (.clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_insn(ex_insn),
    .ex_pc(ex_pc), .ex_len(ex_len), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pc(pc), .psw(psw), .dbg_pc(dbg_pc), .dbg_psw(dbg_psw), .redirect(redirect));

  function automatic logic [31:0] mk(int op, int sub, int b16, logic [31:0] fill);
    logic [31:0] w = fill;
    w[10:5] = op[5:0]; w[26:23] = sub[3:0]; w[16] = b16[0];
    return w;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    chk(req, "pc", pc, m_pc);
    chk(req, "psw", psw, m_psw);
    chk(req, "dbg_pc", dbg_pc, m_dpc);
    chk(req, "dbg_psw", dbg_psw, m_dpsw);
    chk(req, "redirect", redirect, m_red);
  endtask

  task automatic cyc(string req, bit v, logic [31:0] insn, logic [31:0] ipc, int len,
                     bit we, int sel, logic [31:0] wd);
    bit ill;
    longint n_pc = m_pc, n_psw = m_psw, n_dpc = m_dpc, n_dpsw = m_dpsw;
    ex_valid = v; ex_insn = insn; ex_pc = ipc; ex_len = len[2:0];
    wr_en = we; wr_sel = sel[1:0]; wr_data = wd;
    ill = ((insn >> 5) % 64 == 63) && ((insn >> 23) % 16 >= 7) && ((insn >> 16) % 2 == 0);
    if (v && ill) begin
      n_dpc = ipc; n_dpsw = m_psw; n_psw = m_psw | 'h80 | 'h40 | 'h20; n_pc = 'h60;
    end else begin
      if (v) n_pc = (ipc + len) % (64'd1 << 32);
      if (we && sel == 0) n_dpc = wd;
      if (we && sel == 1) n_dpsw = wd;
      if (we && sel == 2) n_psw = wd % 256;
    end
    @(posedge clk);
    @(negedge clk);
    m_pc = n_pc; m_psw = n_psw; m_dpc = n_dpc; m_dpsw = n_dpsw; m_red = v && ill;
    compare(req);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1; fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<5000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_pc = 0; m_psw = 'h20; m_dpc = 0; m_dpsw = 0; m_red = 0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1;
    @(negedge clk);
    compare("R1");
    cyc("R7", 1, 32'h1234_5678, 32'h100, 4, 0, 0, 0);
    cyc("R7", 1, 32'h0000_0000, 32'h104, 2, 0, 0, 0);
    cyc("R8", 0, mk(63, 15, 0, 0), 32'h200, 4, 0, 0, 0);
    cyc("R8", 0, 32'hFFFF_FFFF, 32'h300, 2, 0, 0, 0);
    cyc("R9", 1, mk(63, 6, 0, 0), 32'h108, 4, 0, 0, 0);
    cyc("R9", 1, mk(63, 0, 0, 32'hFFFF_FFFF), 32'h10C, 4, 0, 0, 0);
    cyc("R9", 1, mk(63, 15, 1, 0), 32'h110, 4, 0, 0, 0);
    cyc("R9", 1, mk(62, 15, 0, 32'hFFFF_FFFF), 32'h114, 4, 0, 0, 0);
    cyc("R10", 1, 32'h0, 32'h118, 4, 1, 2, 32'hFFFF_FF1B);
    cyc("R11", 0, 32'h0, 32'h0, 0, 0, 0, 0);
    cyc("R10", 0, 32'h0, 32'h0, 0, 1, 0, 32'hDEAD_BEEF);
    cyc("R10", 0, 32'h0, 32'h0, 0, 1, 1, 32'hCAFE_0001);
    cyc("R10", 0, 32'h0, 32'h0, 0, 1, 3, 32'h5555_5555);
    cyc("R2", 1, mk(63, 7, 0, 0), 32'h0000_4000, 4, 0, 0, 0);
    cyc("R6", 0, 32'h0, 32'h0, 0, 0, 0, 0);
    cyc("R10", 0, 32'h0, 32'h0, 0, 1, 2, 32'h0000_0005);
    cyc("R5", 1, mk(63, 15, 0, 32'hF8FE_F81F), 32'h8000_0010, 4, 0, 0, 0);
    cyc("R3", 1, mk(63, 9, 0, 0), 32'h0000_0060, 4, 0, 0, 0);
    cyc("R4", 1, 32'h0000_0001, 32'h64, 2, 1, 2, 32'h0000_0003);
    cyc("R10", 1, mk(63, 11, 0, 0), 32'h66, 4, 1, 0, 32'h1111_1111);
    cyc("R7", 1, 32'h0000_0002, 32'hFFFF_FFFE, 4, 0, 0, 0);
    for (int s = 0; s < 16; s++) begin
      cyc(s < 7 ? "R9" : "R2", 1, mk(63, s, 0, 0), 32'h1000 + 32'(s * 4), 4, 0, 0, 0);
      cyc("R10", 0, 32'h0, 32'h0, 0, 1, 2, 32'(s));
    end
    rst_n = 0;
    @(negedge clk);
    m_pc = 0; m_psw = 'h20; m_dpc = 0; m_dpsw = 0; m_red = 0;
    compare("R1");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule